// File: doc/BRIEF.md
# Serial-bus control register bank

This block is a two-wire (I2C) target that gives the rest of the chip a small bank of 8-bit control registers loaded over the serial bus. It runs from the system clock and synchronizes SCL and SDA into that clock domain. It detects START and STOP, and it pulls SDA low through an open-drain enable whenever it sends a zero, an acknowledge or a data bit. Every register value is presented at all times on one flat parallel output.

The first byte after the address byte in a write transfer loads a shared register pointer. Each later byte goes into the register that pointer selects, and the pointer then advances. Reads return the register under the pointer and advance it in the same way. A read may therefore follow straight on from the last access ("current address"). It may also be aimed at a chosen register by sending the pointer in a write and then a repeated START with the read bit set. The pointer wraps from the last register back to register 0, whether the access was a read or a write.

Top module: `i2c_regbank`

## Requirements
- R1: The target acknowledges an address byte only when its upper seven bits equal the parameter `DEV_ADDR`. Bit 0 of that byte selects a read (1) or a write (0). After a mismatch the target drives nothing and writes nothing until the next START or STOP.
- R2: In a write transfer, the first byte after the address loads the pointer from its low 5 bits. Each later byte is stored into the register the pointer selects, and the pointer then advances by one. Every such byte is acknowledged.
- R3: The pointer advances from register 6 to register 0. A write burst that runs past register 6 overwrites registers 0, 1 and so on in turn.
- R4: In a read transfer, the target returns the byte under the pointer, most significant bit first, and advances the pointer. Each master ACK makes it send the next byte, wrapping from register 6 to register 0.
- R5: A read that starts with no pointer byte returns register n+1, where n is the register last written or read. Register 0 follows register 6.
- R6: A write carrying only a pointer byte, followed by a repeated START and the address with the read bit set, returns the register at that pointer.
- R7: The target still acknowledges when the pointer holds 7 or more. Writes at such a pointer change no register, and reads at such a pointer return 00h.
- R8: A START seen at any bit position abandons the current byte and begins a new address byte.
- R9: `sda_oe` rises only while the synchronized SCL is low. A value of 1 on `sda_oe` pulls SDA low. The acknowledge is held across the ninth SCL pulse.
- R10: After a master NACK followed by STOP, `sda_oe` is 0 and stays 0.
- R11: Reset (`rst_n` low) sets every register and the pointer to 00h.
- R12: Register k is presented on `regs_o[8k+7:8k]`. Only one register changes in any clock cycle, and it changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock as seen on the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| regs_o | output | 56 | All registers, register k at bits 8k+7:8k |

## Verification
The bench writes bursts from every starting pointer and checks the whole register vector after each one. A pointer that failed to wrap, or wrapped one register late, would leave a stale byte behind, and a burst of nine from register 5 catches it. Current-address reads after both a write and a read catch a design that advances the pointer only on writes, or that returns n instead of n+1. Pointers of 7 and 31 catch a design that stores out-of-range bytes into an aliased register or returns a real register's value. A foreign address, and a START cut into the middle of an address byte, catch a target that acknowledges strangers or resumes the abandoned byte.

// File: rtl/i2crb_pkg.sv
package i2crb_pkg;
   typedef enum logic [2:0] {
      PH_IDLE,
      PH_RECV,
      PH_ACK_OUT,
      PH_SEND,
      PH_ACK_IN
   } phase_t;

   typedef enum logic [1:0] {
      BY_DEVADDR,
      BY_POINTER,
      BY_PAYLOAD
   } byte_kind_t;
endpackage

// File: rtl/i2crb_sync.sv
module i2crb_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   if (STAGES < 2) begin : g_bad_stages
      $error("i2crb_sync: STAGES must be at least 2");
   end

   logic [1:0] chain [STAGES];
   logic       scl_prev, sda_prev;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain[s] <= 2'b11;
            else        chain[s] <= {scl_i, sda_i};
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain[s] <= 2'b11;
            else        chain[s] <= chain[s-1];
      end
   end

   assign scl_s = chain[STAGES-1][1];
   assign sda_s = chain[STAGES-1][0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_prev <= 1'b1;
         sda_prev <= 1'b1;
      end else begin
         scl_prev <= scl_s;
         sda_prev <= sda_s;
      end
   end

   assign scl_rise  = scl_s & ~scl_prev;
   assign scl_fall  = ~scl_s & scl_prev;
   assign start_det = scl_s & scl_prev & sda_prev & ~sda_s;
   assign stop_det  = scl_s & scl_prev & ~sda_prev & sda_s;
endmodule

// File: rtl/i2crb_regs.sv
module i2crb_regs #(
   parameter int NUM_REGS = 7,
   parameter int DATA_W   = 8,
   parameter int PTR_W    = 5
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [PTR_W-1:0]           wr_addr,
   input  logic [DATA_W-1:0]          wr_data,
   input  logic [PTR_W-1:0]           rd_addr,
   output logic [DATA_W-1:0]          rd_data,
   output logic [NUM_REGS*DATA_W-1:0] regs_flat
);
   if (NUM_REGS > (1 << PTR_W)) begin : g_bad_depth
      $error("i2crb_regs: NUM_REGS exceeds the pointer range");
   end

   for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                 q <= '0;
         else if (wr_en && wr_addr == PTR_W'(k))     q <= wr_data;
      end
      assign regs_flat[k*DATA_W +: DATA_W] = q;
   end

   always_comb begin
      rd_data = '0;
      for (int k = 0; k < NUM_REGS; k++)
         if (rd_addr == PTR_W'(k)) rd_data = regs_flat[k*DATA_W +: DATA_W];
   end
endmodule

// File: rtl/i2crb_engine.sv
module i2crb_engine
   import i2crb_pkg::*;
#(
   parameter int          NUM_REGS = 7,
   parameter int          PTR_W    = 5,
   parameter logic [6:0]  DEV_ADDR = 7'h2C
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sda_s,
   input  logic             scl_rise,
   input  logic             scl_fall,
   input  logic             start_det,
   input  logic             stop_det,
   input  logic [7:0]       rd_data,
   output logic [PTR_W-1:0] ptr,
   output logic             wr_en,
   output logic [PTR_W-1:0] wr_addr,
   output logic [7:0]       wr_data,
   output logic             sda_oe
);
   localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_REGS - 1);

   if (PTR_W > 8) begin : g_bad_ptr
      $error("i2crb_engine: PTR_W must fit in one byte");
   end

   phase_t     phase;
   byte_kind_t kind;
   logic [2:0] bitcnt;
   logic [7:0] shreg;
   logic       full;
   logic       rw;
   logic       nack;

   function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
      return (p == LAST) ? '0 : p + PTR_W'(1);
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase   <= PH_IDLE;
         kind    <= BY_DEVADDR;
         bitcnt  <= '0;
         shreg   <= '0;
         full    <= 1'b0;
         rw      <= 1'b0;
         nack    <= 1'b0;
         ptr     <= '0;
         wr_en   <= 1'b0;
         wr_addr <= '0;
         wr_data <= '0;
         sda_oe  <= 1'b0;
      end else begin
         wr_en <= 1'b0;
         if (start_det) begin
            phase  <= PH_RECV;
            kind   <= BY_DEVADDR;
            bitcnt <= '0;
            full   <= 1'b0;
            sda_oe <= 1'b0;
         end else if (stop_det) begin
            phase  <= PH_IDLE;
            full   <= 1'b0;
            sda_oe <= 1'b0;
         end else begin
            unique case (phase)
               PH_IDLE: ;
               PH_RECV: begin
                  if (scl_rise && !full) begin
                     shreg  <= {shreg[6:0], sda_s};
                     bitcnt <= bitcnt + 3'd1;
                     if (bitcnt == 3'd7) full <= 1'b1;
                  end else if (scl_fall && full) begin
                     full <= 1'b0;
                     unique case (kind)
                        BY_DEVADDR: begin
                           if (shreg[7:1] == DEV_ADDR) begin
                              rw     <= shreg[0];
                              sda_oe <= 1'b1;
                              phase  <= PH_ACK_OUT;
                           end else begin
                              phase  <= PH_IDLE;
                           end
                        end
                        BY_POINTER: begin
                           ptr    <= shreg[PTR_W-1:0];
                           sda_oe <= 1'b1;
                           phase  <= PH_ACK_OUT;
                        end
                        default: begin
                           wr_en   <= 1'b1;
                           wr_addr <= ptr;
                           wr_data <= shreg;
                           ptr     <= step(ptr);
                           sda_oe  <= 1'b1;
                           phase   <= PH_ACK_OUT;
                        end
                     endcase
                  end
               end
               PH_ACK_OUT: begin
                  if (scl_fall) begin
                     bitcnt <= '0;
                     if (kind == BY_DEVADDR && rw) begin
                        shreg  <= rd_data;
                        sda_oe <= ~rd_data[7];
                        ptr    <= step(ptr);
                        phase  <= PH_SEND;
                     end else begin
                        sda_oe <= 1'b0;
                        phase  <= PH_RECV;
                        kind   <= (kind == BY_DEVADDR) ? BY_POINTER : BY_PAYLOAD;
                     end
                  end
               end
               PH_SEND: begin
                  if (scl_fall) begin
                     if (bitcnt == 3'd7) begin
                        sda_oe <= 1'b0;
                        phase  <= PH_ACK_IN;
                     end else begin
                        bitcnt <= bitcnt + 3'd1;
                        shreg  <= {shreg[6:0], 1'b0};
                        sda_oe <= ~shreg[6];
                     end
                  end
               end
               PH_ACK_IN: begin
                  if (scl_rise) begin
                     nack <= sda_s;
                  end else if (scl_fall) begin
                     bitcnt <= '0;
                     if (nack) begin
                        phase <= PH_IDLE;
                     end else begin
                        shreg  <= rd_data;
                        sda_oe <= ~rd_data[7];
                        ptr    <= step(ptr);
                        phase  <= PH_SEND;
                     end
                  end
               end
               default: phase <= PH_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/i2c_regbank.sv
module i2c_regbank #(
   parameter int          NUM_REGS    = 7,
   parameter int          PTR_W       = 5,
   parameter int          SYNC_STAGES = 2,
   parameter logic [6:0]  DEV_ADDR    = 7'h2C
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  scl_i,
   input  logic                  sda_i,
   output logic                  sda_oe,
   output logic [NUM_REGS*8-1:0] regs_o
);
   localparam int DATA_W = 8;

   if (NUM_REGS < 1) begin : g_bad_regs
      $error("i2c_regbank: NUM_REGS must be positive");
   end

   logic             scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
   logic [PTR_W-1:0] ptr, wr_addr;
   logic             wr_en;
   logic [7:0]       wr_data, rd_data;

   i2crb_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det)
   );

   i2crb_engine #(.NUM_REGS(NUM_REGS), .PTR_W(PTR_W), .DEV_ADDR(DEV_ADDR)) u_engine (
      .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det), .rd_data(rd_data), .ptr(ptr),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .sda_oe(sda_oe)
   );

   i2crb_regs #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .PTR_W(PTR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(ptr), .rd_data(rd_data), .regs_flat(regs_o)
   );
endmodule

// File: rtl/i2c_regbank_chk.sv
module i2c_regbank_chk #(
   parameter int NUM_REGS = 7
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  scl_s,
   input logic                  stop_det,
   input logic                  sda_oe,
   input logic [NUM_REGS*8-1:0] regs_o
);
   logic [NUM_REGS*8-1:0] regs_q;
   logic [NUM_REGS-1:0]   chg;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) regs_q <= '0;
      else        regs_q <= regs_o;

   for (genvar k = 0; k < NUM_REGS; k++) begin : g_cmp
      assign chg[k] = regs_q[k*8 +: 8] != regs_o[k*8 +: 8];
   end

   // R9
   oe_rise_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> !scl_s);

   // R10
   stop_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !sda_oe);

   // R12
   one_reg_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(chg) <= 1);

   // R12
   reg_change_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chg != '0) |-> !scl_s);
endmodule

bind i2c_regbank i2c_regbank_chk #(.NUM_REGS(NUM_REGS)) u_chk (
   .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .stop_det(stop_det),
   .sda_oe(sda_oe), .regs_o(regs_o)
);

// File: tb/i2c_regbank_tb.sv
module i2c_regbank_tb;
   localparam int         NREG = 7;
   localparam logic [6:0] DEV  = 7'h2C;
   localparam int         Q    = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl = 1'b1;
   logic m_low = 1'b0;
   logic sda_oe;
   logic [NREG*8-1:0] regs_o;
   wire  sda_bus = !(m_low || sda_oe);

   int checks = 0;
   int failures = 0;
   logic [7:0] mreg [NREG];
   logic [4:0] mptr;

   always #10 clk = ~clk;

   i2c_regbank #(.NUM_REGS(NREG), .DEV_ADDR(DEV)) u_dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
      .sda_oe(sda_oe), .regs_o(regs_o)
   );

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic hold(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [4:0] adv(input logic [4:0] p);
      return (p == 5'd6) ? 5'd0 : p + 5'd1;
   endfunction

   function automatic logic [NREG*8-1:0] mvec();
      logic [NREG*8-1:0] v;
      for (int k = 0; k < NREG; k++) v[k*8 +: 8] = mreg[k];
      return v;
   endfunction

   function automatic logic [7:0] mread(input logic [4:0] p);
      return (p < 5'd7) ? mreg[p] : 8'h00;
   endfunction

   task automatic bus_start();
      scl = 1'b0; hold(Q);
      m_low = 1'b0; hold(Q);
      scl = 1'b1; hold(Q);
      m_low = 1'b1; hold(Q);
      scl = 1'b0; hold(Q);
   endtask

   task automatic bus_stop();
      scl = 1'b0; hold(Q);
      m_low = 1'b1; hold(Q);
      scl = 1'b1; hold(Q);
      m_low = 1'b0; hold(2*Q);
   endtask

   task automatic put_bit(input bit b);
      m_low = !b; hold(Q);
      scl = 1'b1; hold(2*Q);
      scl = 1'b0; hold(Q);
   endtask

   task automatic get_bit(output bit b);
      m_low = 1'b0; hold(Q);
      scl = 1'b1; hold(Q);
      b = sda_bus; hold(Q);
      scl = 1'b0; hold(Q);
   endtask

   task automatic send_byte(input logic [7:0] v, output bit acked);
      bit a;
      for (int i = 7; i >= 0; i--) put_bit(v[i]);
      get_bit(a);
      acked = !a;
   endtask

   task automatic recv_byte(output logic [7:0] v, input bit more);
      bit b;
      for (int i = 7; i >= 0; i--) begin
         get_bit(b);
         v[i] = b;
      end
      put_bit(!more);
   endtask

   task automatic write_burst(input logic [7:0] p, input int n, input logic [7:0] base, input string req);
      bit a;
      bus_start();
      send_byte({DEV, 1'b0}, a);
      check(a, {req, " address ack"}, a, 1);
      send_byte(p, a);
      check(a, {req, " pointer ack"}, a, 1);
      mptr = p[4:0];
      for (int k = 0; k < n; k++) begin
         send_byte(base + 8'(k), a);
         check(a, {req, " data ack"}, a, 1);
         if (mptr < 5'd7) mreg[mptr] = base + 8'(k);
         mptr = adv(mptr);
      end
      bus_stop();
      check(regs_o == mvec(), {req, " register vector"}, regs_o, mvec());
   endtask

   task automatic read_body(input int n, input string req);
      logic [7:0] v;
      bit a;
      send_byte({DEV, 1'b1}, a);
      check(a, {req, " read address ack"}, a, 1);
      for (int k = 0; k < n; k++) begin
         recv_byte(v, k != n - 1);
         check(v == mread(mptr), {req, " read data"}, v, mread(mptr));
         mptr = adv(mptr);
      end
      bus_stop();
      check(sda_oe == 1'b0, "R10 released after nack+stop", sda_oe, 0);
   endtask

   task automatic read_current(input int n, input string req);
      bus_start();
      read_body(n, req);
   endtask

   task automatic read_random(input logic [7:0] p, input int n, input string req);
      bit a;
      bus_start();
      send_byte({DEV, 1'b0}, a);
      check(a, {req, " address ack"}, a, 1);
      send_byte(p, a);
      check(a, {req, " pointer ack"}, a, 1);
      mptr = p[4:0];
      bus_start();
      read_body(n, req);
   endtask

   initial begin
      for (int k = 0; k < NREG; k++) mreg[k] = 8'h00;
      mptr = 5'd0;
      hold(5);
      rst_n = 1'b1;
      hold(5);
      // R11 reset state
      check(regs_o == '0, "R11 reset registers", regs_o, 0);
      check(sda_oe == 1'b0, "R11 reset sda idle", sda_oe, 0);
      read_current(2, "R11 R5 pointer starts at 0");

      // R2 R3 sweep of every start pointer
      for (int s = 0; s < NREG; s++)
         write_burst(8'(s), 3, 8'(8'h10 * (s + 1)), "R2 R3 burst sweep");
      write_burst(8'h05, 9, 8'hA0, "R3 long wrap burst");

      // R6 random read of every register
      for (int s = 0; s < NREG; s++)
         read_random(8'(s), 2, "R6 R4 random read");

      // R5 current read after a write and after a read
      write_burst(8'h02, 1, 8'h5A, "R2 single write");
      read_current(1, "R5 current after write");
      read_current(3, "R5 current after read");
      read_random(8'h04, 9, "R4 sequential wrap read");

      // R7 out of range pointers
      write_burst(8'h07, 2, 8'hEE, "R7 write at 7");
      write_burst(8'h1F, 2, 8'hDD, "R7 write at 31");
      read_random(8'h07, 1, "R7 read at 7");
      read_random(8'h1F, 3, "R7 read at 31 then wrap");

      // R1 foreign address, write then read
      begin
         bit a;
         logic [7:0] v;
         bus_start();
         send_byte({DEV ^ 7'h01, 1'b0}, a);
         check(!a, "R1 foreign address nack", a, 0);
         send_byte(8'h00, a);
         check(!a, "R1 ignored pointer nack", a, 0);
         send_byte(8'h99, a);
         check(!a, "R1 ignored data nack", a, 0);
         bus_stop();
         check(regs_o == mvec(), "R1 registers untouched", regs_o, mvec());
         bus_start();
         send_byte({DEV ^ 7'h40, 1'b1}, a);
         check(!a, "R1 foreign read nack", a, 0);
         recv_byte(v, 1'b0);
         check(v == 8'hFF, "R1 foreign read bus idle", v, 8'hFF);
         bus_stop();
      end

      // R8 START in the middle of an address byte
      bus_start();
      put_bit(1'b0); put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
      write_burst(8'h03, 2, 8'h3C, "R8 restart mid byte");
      read_random(8'h03, 2, "R8 read after restart");

      // R12 field positions
      check(regs_o[3*8 +: 8] == 8'h3C, "R12 register 3 position", regs_o[3*8 +: 8], 8'h3C);
      check(regs_o[4*8 +: 8] == 8'h3D, "R12 register 4 position", regs_o[4*8 +: 8], 8'h3D);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule